// File: doc/BRIEF.md
# Credit-Pool Flow-Control Sender

This block is the transmit half of a pipeline stage. It forwards words from a local producer to a downstream stage that has a fixed number of buffer slots, `DEPTH`. The sender keeps an up/down credit counter equal to the number of free downstream slots. It starts full, so the first word can leave right after reset. A word is taken from the producer only while at least one credit is held. Each word taken is sent on the next cycle with a one-cycle indication strobe. The downstream stage hands slots back with one-cycle credit strobes.

Because credits are counted, up to `DEPTH` words can be in flight without waiting for any return. This hides the round trip of the link. With `DEPTH = 1` the block falls back to a strict one-word-then-wait handshake. A credit strobe that arrives while the pool is already full breaks the protocol. The block flags it and drops the extra credit.

Top module: `credit_tx`

## Requirements
- R1: After reset the pool holds `DEPTH` credits, `prod_ready_o` is high, and `dn_ind_o` and `crd_err_o` are low.
- R2: `prod_ready_o` is high exactly when the pool is non-zero. A word is accepted in a cycle where `prod_valid_i` and `prod_ready_o` are both high, and each accepted word uses one credit.
- R3: `dn_ind_o` is high for one cycle, in the cycle after each accepted word. In that cycle `dn_data_o` carries that word, and words leave in acceptance order.
- R4: After `DEPTH` accepted words with no credit returned, `prod_ready_o` is low and no indication is sent, however long `prod_valid_i` stays high.
- R5: A `crd_ret_i` pulse adds one credit. A producer word held back for lack of credit is accepted in the cycle after the return, whichever of the word and the credit came first.
- R6: A credit return and an accepted word in the same cycle, with the pool below `DEPTH`, leave the credit count unchanged.
- R7: A `crd_ret_i` pulse while the pool holds `DEPTH` credits raises `crd_err_o` for exactly the next cycle. The pool stays at `DEPTH`, so only `DEPTH` words can be accepted afterwards before a stall.
- R8: `dn_data_o` holds its value in every cycle in which `dn_ind_o` is low.
- R9: With `DEPTH = 1`, `prod_ready_o` drops after each accepted word and rises only in the cycle after a credit return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prod_valid_i | input | 1 | Producer offers a word |
| prod_data_i | input | WIDTH | Offered word |
| prod_ready_o | output | 1 | Word is taken this cycle when the offer is valid |
| dn_ind_o | output | 1 | One-cycle indication that a word is on `dn_data_o` |
| dn_data_o | output | WIDTH | Word sent downstream |
| crd_ret_i | input | 1 | One-cycle credit return from downstream |
| crd_err_o | output | 1 | One-cycle flag for a credit returned into a full pool |

## Verification
The checks rely on the producer behaving as an offer/accept source that changes its word only after acceptance. They also rely on `crd_ret_i` being a single-cycle strobe, with at most one credit per cycle. The bench drives all inputs on the falling edge and changes the offered word only after a completed transfer. It returns credits one pulse at a time. A return into a full pool is made only on purpose, to exercise the error flag. Apart from that case, the number of credits returned never exceeds the number of words sent, so the range check on the counter reflects legal traffic.

// File: rtl/credit_tx_pkg.sv
package credit_tx_pkg;
  localparam int unsigned MAX_DEPTH = 8;

  function automatic int unsigned cnt_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/credit_pool.sv
module credit_pool #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = credit_tx_pkg::cnt_bits(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          ret_i,
  output logic          avail_o,
  output logic [CW-1:0] cnt_o,
  output logic          err_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, inc;

  assign full    = (cnt_q == CW'(DEPTH));
  assign inc     = ret_i && !full;          // credit into full pool is dropped
  assign cnt_d   = cnt_q + CW'(inc) - CW'(take_i);
  assign avail_o = (cnt_q != '0);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(DEPTH);
      err_o <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_o <= ret_i && full;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  // R6
  cnt_balance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && ret_i && !full) |=> $stable(cnt_q));

  // R7
  err_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && full) |=> (err_o && cnt_q <= CW'(DEPTH)));
endmodule

// File: rtl/launch_stage.sv
module launch_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             ind_o,
  output logic [WIDTH-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ind_o  <= 1'b0;
      data_o <= '0;
    end else begin
      ind_o <= fire_i;
      if (fire_i) data_o <= data_i;
    end
  end

  // R8
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ind_o |-> $stable(data_o));
endmodule

// File: rtl/credit_tx.sv
module credit_tx #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CW = credit_tx_pkg::cnt_bits(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prod_valid_i,
  input  logic [WIDTH-1:0] prod_data_i,
  output logic             prod_ready_o,
  output logic             dn_ind_o,
  output logic [WIDTH-1:0] dn_data_o,
  input  logic             crd_ret_i,
  output logic             crd_err_o
);
  logic          take;
  logic [CW-1:0] cnt;

  initial begin
    if (DEPTH < 1 || DEPTH > credit_tx_pkg::MAX_DEPTH)
      $error("DEPTH out of range");
  end

  assign take = prod_valid_i && prod_ready_o;

  credit_pool #(.DEPTH(DEPTH)) u_pool (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .ret_i   (crd_ret_i),
    .avail_o (prod_ready_o),
    .cnt_o   (cnt),
    .err_o   (crd_err_o)
  );

  launch_stage #(.WIDTH(WIDTH)) u_launch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (take),
    .data_i (prod_data_i),
    .ind_o  (dn_ind_o),
    .data_o (dn_data_o)
  );

  // R3
  ind_follows_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (dn_ind_o && dn_data_o == $past(prod_data_i)));

  // R4
  no_launch_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) |=> !dn_ind_o);

  // R5
  ret_wakes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && crd_ret_i) |=> prod_ready_o);
endmodule

// File: tb/credit_tx_bench.sv
module credit_tx_bench;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned WIDTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             valid = 1'b0, ret = 1'b0;
  logic [WIDTH-1:0] data = '0;
  logic             ready, ind, err;
  logic [WIDTH-1:0] dout;

  logic             v1 = 1'b0, ret1 = 1'b0;
  logic [WIDTH-1:0] d1 = '0;
  logic             ready1, ind1, err1;
  logic [WIDTH-1:0] dout1;

  credit_tx #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_credit_tx (
    .clk_i(clk), .rst_ni(rst_n), .prod_valid_i(valid), .prod_data_i(data),
    .prod_ready_o(ready), .dn_ind_o(ind), .dn_data_o(dout),
    .crd_ret_i(ret), .crd_err_o(err));

  credit_tx #(.DEPTH(1), .WIDTH(WIDTH)) u_one (
    .clk_i(clk), .rst_ni(rst_n), .prod_valid_i(v1), .prod_data_i(d1),
    .prod_ready_o(ready1), .dn_ind_o(ind1), .dn_data_o(dout1),
    .crd_ret_i(ret1), .crd_err_o(err1));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [WIDTH-1:0] exp_q[$];
  logic [WIDTH-1:0] last_out = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: R3 ordering and data, R8 hold
  always @(negedge clk) begin
    if (rst_n) begin
      if (ind) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected indication", 1, 0);
        else begin
          logic [WIDTH-1:0] e;
          e = exp_q.pop_front();
          chk(dout == e, "R3 data", dout, e);
        end
        last_out = dout;
      end else if (dout != last_out) begin
        chk(0, "R8 data hold", dout, last_out);
      end
    end
  end

  task automatic send(input logic [WIDTH-1:0] d);
    @(negedge clk);
    valid = 1'b1; data = d;
    while (!ready) @(negedge clk);
    exp_q.push_back(d);
    @(posedge clk); #1;
    valid = 1'b0;
  endtask

  task automatic give_credit();
    @(negedge clk);
    ret = 1'b1;
    @(posedge clk); #1;
    ret = 1'b0;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all words delivered", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    chk(ind == 1'b0, "R1 ind after reset", ind, 0);
    chk(err == 1'b0, "R1 err after reset", err, 0);
    chk(ready1 == 1'b1, "R1 depth-1 ready after reset", ready1, 1);

    // R2/R4: burst of DEPTH words with no returns, then stall
    for (int i = 0; i < DEPTH; i++) send(8'h10 + 8'(i));
    @(negedge clk);
    valid = 1'b1; data = 8'hA5;
    for (int i = 0; i < 5; i++) begin
      chk(ready == 1'b0, "R4 stalled when pool empty", ready, 0);
      @(negedge clk);
    end
    // R5: word waited, credit arrives later
    ret = 1'b1;
    @(posedge clk); #1 ret = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R5 ready after credit return", ready, 1);
    exp_q.push_back(8'hA5);
    @(posedge clk); #1 valid = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0, "R2 credit used by launch", ready, 0);
    drain();

    // R5: credit first, word later
    give_credit();
    repeat (2) @(negedge clk);
    chk(ready == 1'b1, "R5 credit held before offer", ready, 1);
    // R6: return and launch in the same cycle, pool at 1
    @(negedge clk);
    valid = 1'b1; data = 8'h5C; ret = 1'b1;
    exp_q.push_back(8'h5C);
    @(posedge clk); #1 valid = 1'b0; ret = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R6 count unchanged on balanced cycle", ready, 1);
    send(8'h5D);
    @(negedge clk);
    chk(ready == 1'b0, "R6 exactly one credit was left", ready, 0);
    drain();

    // refill to DEPTH
    for (int i = 0; i < DEPTH; i++) give_credit();
    @(negedge clk);
    chk(err == 1'b0, "R7 no error on legal refill", err, 0);
    // R7: extra credit into full pool
    @(negedge clk);
    ret = 1'b1;
    @(posedge clk); #1 ret = 1'b0;
    @(negedge clk);
    chk(err == 1'b1, "R7 error flagged", err, 1);
    @(negedge clk);
    chk(err == 1'b0, "R7 error is one cycle", err, 0);
    for (int i = 0; i < DEPTH; i++) send(8'hC0 + 8'(i));
    @(negedge clk);
    chk(ready == 1'b0, "R7 pool saturated at DEPTH", ready, 0);
    drain();

    // R9: depth-1 handshake
    @(negedge clk);
    v1 = 1'b1; d1 = 8'h77;
    @(posedge clk); #1 v1 = 1'b0;
    @(negedge clk);
    chk(ind1 == 1'b1 && dout1 == 8'h77, "R9 word sent", dout1, 8'h77);
    chk(ready1 == 1'b0, "R9 ready low after one word", ready1, 0);
    @(negedge clk);
    chk(ind1 == 1'b0, "R9 indication one cycle", ind1, 0);
    ret1 = 1'b1;
    @(posedge clk); #1 ret1 = 1'b0;
    @(negedge clk);
    chk(ready1 == 1'b1, "R9 ready after credit", ready1, 1);

    drain();
    done = 1;
    finish_run();
  end
endmodule